// File: doc/BRIEF.md
# Latched-Address Programmable Byte Memory

This block is a byte-wide, one-time-programmable style memory with an address latch built into it. Because of the latch it can hang directly off a bus that carries the address and then the data on the same wires. While the strobe input is high the latch passes the address through. While the strobe is low the latch keeps the last address it captured, so the bus can go on to carry data. A small decoder turns the two active-low enables, the program-supply select and the signature select into one of seven modes: MD_READ, MD_SIGNATURE, MD_DISABLE, MD_STANDBY, MD_PROGRAM, MD_VERIFY and MD_INHIBIT. Only MD_READ, MD_SIGNATURE and MD_VERIFY drive the data bus.

Reset leaves the array in the erased state. An erase sequencer has two states, ER_SWEEP and ER_DONE. ER_SWEEP writes 0xFF to every byte, one byte per cycle, and moves to ER_DONE after the last address. Programming is tracked by a second machine with the states PG_IDLE and PG_ARMED. Any cycle in MD_PROGRAM moves it to PG_ARMED and captures the latched address and the input byte. From PG_ARMED it returns to PG_IDLE in one of two ways:
- If chip enable is seen high with the program supply still selected, the captured byte is ANDed into the array at that edge.
- On any other exit from MD_PROGRAM, it returns without writing.

Because the write is an AND, programming can only clear bits. The bus drive is registered: `dq_oe` and `dq_out` reflect the controls and address presented before the previous clock edge. `dq_oe` is meant for an external tri-state buffer.

Top module: `lap_mem_top`

## Requirements
- R1: The array holds 2**ADDR_W bytes of 8 bits. After reset is released, the array needs 2**ADDR_W cycles to sweep to the erased state. During that time `dq_oe` stays 0 and program pulses are ignored. After the sweep, every byte reads 0xFF.
- R2: While `strobe` is 1, the address used for reading and programming is the current `addr_in`.
- R3: While `strobe` is 0, the address is held at the value `addr_in` had at the last clock edge where `strobe` was 1. Changes on `addr_in` then have no effect.
- R4: Read mode is `ce_n`=0, `oe_n`=0, `prog_en`=0 and `sig_en`=0. In read mode, one cycle after the inputs are presented, `dq_oe`=1 and `dq_out` equals the addressed byte.
- R5: With `prog_en`=0 and `ce_n`=1 (standby), `dq_oe` is 0 one cycle later, whatever the value of `oe_n`.
- R6: With `prog_en`=0, `ce_n`=0 and `oe_n`=1, `dq_oe` is 0 one cycle later.
- R7: Signature mode is `ce_n`=0, `oe_n`=0, `prog_en`=0 and `sig_en`=1. One cycle later `dq_oe`=1 and `dq_out` shows a code chosen by address bit 0: 0x20 when the bit is 0 and 0x80 when it is 1. With `oe_n`=1 the bus is not driven.
- R8: A program pulse is one or more cycles with `prog_en`=1, `ce_n`=0 and `oe_n`=1, followed by a cycle with `prog_en`=1 and `ce_n`=1. At that rising edge of chip enable, the addressed byte becomes old AND `dq_in`. The address is the latched address from the last cycle that `ce_n` was low, and `dq_in` is sampled in that same cycle.
- R9: Repeated program pulses on one byte accumulate. The byte ends as the AND of the erased value and every byte written to it.
- R10: Verify mode is `prog_en`=1, `ce_n`=1 and `oe_n`=0. One cycle later `dq_oe`=1 and `dq_out` shows the addressed array byte, whatever the value of `sig_en`.
- R11: With `prog_en`=1 and both enables at 1 (program inhibit), the array is not written and `dq_oe` is 0. With `prog_en`=1 and both enables at 0, `dq_oe` is also 0.
- R12: A low pulse on `ce_n` does not write in two cases: when `prog_en` is 0, or when `prog_en` falls before `ce_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; starts the erase sweep |
| addr_in | input | ADDR_W | Address inputs to the latch |
| dq_in | input | 8 | Byte to program |
| ce_n | input | 1 | Active-low chip enable; its rising edge ends a program pulse |
| oe_n | input | 1 | Active-low output enable |
| strobe | input | 1 | Latch control: 1 passes the address through, 0 holds it |
| prog_en | input | 1 | Program-supply select |
| sig_en | input | 1 | Signature readout select |
| dq_out | output | 8 | Registered data for the bus |
| dq_oe | output | 1 | Registered bus drive enable |

## Verification
The bench builds the block with ADDR_W=6, which gives 64 bytes. At that size the whole erase sweep fits in a short run, and the bench reads back every address, including the top one at 63. The signature codes keep their default values, so both codes and the effect of address bit 0 on an ordinary even or odd address can be checked. The small depth also lets the held-address tests move `addr_in` between widely separated locations, and the bench confirms that a byte next to a programmed one stays erased.

// File: rtl/lap_mem_pkg.sv
package lap_mem_pkg;

    typedef enum logic [2:0] {
        MD_STANDBY,
        MD_DISABLE,
        MD_READ,
        MD_SIGNATURE,
        MD_PROGRAM,
        MD_VERIFY,
        MD_INHIBIT
    } lap_mode_e;

    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] ERASED_BYTE = 8'hFF;

endpackage

// File: rtl/lap_addr_latch.sv
module lap_addr_latch #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_eff
);

    logic [ADDR_W-1:0] held_q;
    logic              past_ok;

    assign addr_eff = strobe ? addr_in : held_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q  <= '0;
            past_ok <= 1'b0;
        end else begin
            held_q  <= addr_eff;
            past_ok <= 1'b1;
        end
    end

    // R3: a low strobe keeps the address seen by the array fixed
    assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !strobe) |-> (addr_eff == $past(addr_eff)));

endmodule

// File: rtl/lap_mode_dec.sv
module lap_mode_dec
    import lap_mem_pkg::*;
(
    input  logic      ce_n,
    input  logic      oe_n,
    input  logic      prog_en,
    input  logic      sig_en,
    output lap_mode_e mode
);

    always_comb begin
        unique case ({prog_en, ce_n, oe_n})
            3'b000:  mode = sig_en ? MD_SIGNATURE : MD_READ;
            3'b001:  mode = MD_DISABLE;
            3'b010:  mode = MD_STANDBY;
            3'b011:  mode = MD_STANDBY;
            3'b100:  mode = MD_INHIBIT;
            3'b101:  mode = MD_PROGRAM;
            3'b110:  mode = MD_VERIFY;
            3'b111:  mode = MD_INHIBIT;
            default: mode = MD_STANDBY;
        endcase
    end

endmodule

// File: rtl/lap_prog_seq.sv
module lap_prog_seq
    import lap_mem_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  lap_mode_e         mode,
    input  logic              prog_en,
    input  logic              ce_n,
    input  logic [ADDR_W-1:0] addr_eff,
    input  logic [BYTE_W-1:0] dq_in,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data
);

    typedef enum logic {PG_IDLE, PG_ARMED} pg_state_e;

    pg_state_e state_q, state_d;
    logic      past_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PG_IDLE;
            past_ok <= 1'b0;
        end else begin
            state_q <= state_d;
            past_ok <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_addr <= '0;
            wr_data <= '0;
        end else if (mode == MD_PROGRAM) begin
            wr_addr <= addr_eff;
            wr_data <= dq_in;
        end
    end

    always_comb begin
        state_d = state_q;
        wr_en   = 1'b0;
        unique case (state_q)
            PG_IDLE: begin
                if (mode == MD_PROGRAM) state_d = PG_ARMED;
            end
            PG_ARMED: begin
                if (mode == MD_PROGRAM) begin
                    state_d = PG_ARMED;
                end else begin
                    state_d = PG_IDLE;
                    wr_en   = prog_en && ce_n;
                end
            end
            default: state_d = PG_IDLE;
        endcase
    end

    // R8: a write only closes a pulse that was in program mode on the previous cycle
    assert_write_after_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && wr_en) |-> ($past(mode) == MD_PROGRAM));

    // R12: no write once the program supply has been removed
    assert_no_write_unsupplied_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> prog_en);

endmodule

// File: rtl/lap_mem_array.sv
module lap_mem_array
    import lap_mem_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic              ready
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

    typedef enum logic {ER_SWEEP, ER_DONE} er_state_e;

    logic [BYTE_W-1:0] mem [DEPTH];
    er_state_e         er_q, er_d;
    logic [ADDR_W-1:0] sweep_q;
    logic              past_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            er_q    <= ER_SWEEP;
            sweep_q <= '0;
            past_ok <= 1'b0;
        end else begin
            er_q    <= er_d;
            past_ok <= 1'b1;
            if (er_q == ER_SWEEP) sweep_q <= sweep_q + 1'b1;
        end
    end

    always_comb begin
        er_d = er_q;
        unique case (er_q)
            ER_SWEEP: if (sweep_q == LAST_ADDR) er_d = ER_DONE;
            ER_DONE:  er_d = ER_DONE;
            default:  er_d = ER_SWEEP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst_n && er_q == ER_SWEEP) begin
            mem[sweep_q] <= ERASED_BYTE;
        end else if (rst_n && wr_en) begin
            mem[wr_addr] <= mem[wr_addr] & wr_data;
        end
    end

    assign rd_data = mem[rd_addr];
    assign ready   = (er_q == ER_DONE);

    // R1: the array becomes ready only after the sweep reached the last address
    assert_sweep_complete_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(ready)) |-> ($past(sweep_q) == LAST_ADDR));

endmodule

// File: rtl/lap_mem_top.sv
module lap_mem_top
    import lap_mem_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter logic [7:0] MFR_CODE = 8'h20,
    parameter logic [7:0] DEV_CODE = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [7:0]        dq_in,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              strobe,
    input  logic              prog_en,
    input  logic              sig_en,
    output logic [7:0]        dq_out,
    output logic              dq_oe
);

    lap_mode_e         mode;
    logic [ADDR_W-1:0] addr_eff;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [BYTE_W-1:0] wr_data;
    logic [BYTE_W-1:0] rd_data;
    logic              ready;
    logic              drive;
    logic [BYTE_W-1:0] bus_d;
    logic              past_ok;

    lap_addr_latch #(.ADDR_W(ADDR_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .strobe(strobe),
        .addr_in(addr_in), .addr_eff(addr_eff)
    );

    lap_mode_dec u_dec (
        .ce_n(ce_n), .oe_n(oe_n), .prog_en(prog_en),
        .sig_en(sig_en), .mode(mode)
    );

    lap_prog_seq #(.ADDR_W(ADDR_W)) u_prog (
        .clk(clk), .rst_n(rst_n), .mode(mode), .prog_en(prog_en),
        .ce_n(ce_n), .addr_eff(addr_eff), .dq_in(dq_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    lap_mem_array #(.ADDR_W(ADDR_W)) u_array (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(addr_eff), .rd_data(rd_data),
        .ready(ready)
    );

    always_comb begin
        drive = 1'b0;
        bus_d = rd_data;
        unique case (mode)
            MD_READ:      drive = 1'b1;
            MD_VERIFY:    drive = 1'b1;
            MD_SIGNATURE: begin
                drive = 1'b1;
                bus_d = addr_eff[0] ? DEV_CODE : MFR_CODE;
            end
            default:      drive = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_oe   <= 1'b0;
            dq_out  <= '0;
            past_ok <= 1'b0;
        end else begin
            dq_oe   <= drive && ready;
            dq_out  <= bus_d;
            past_ok <= 1'b1;
        end
    end

    // R4: the bus is driven only after a cycle in a reading mode
    assert_drive_modes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && dq_oe) |->
        ($past(mode) == MD_READ || $past(mode) == MD_SIGNATURE || $past(mode) == MD_VERIFY));

    // R5: standby keeps the bus released regardless of output enable
    assert_standby_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(ce_n && !prog_en)) |-> !dq_oe);

    // R7: signature readout shows one of the two fixed codes
    assert_sig_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && dq_oe && $past(mode) == MD_SIGNATURE) |->
        (dq_out == MFR_CODE || dq_out == DEV_CODE));

    // R1: nothing is driven while the erase sweep is running
    assert_quiet_sweep_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(ready)) |-> !dq_oe);

endmodule

// File: tb/tb_lap_mem_top.sv
`timescale 1ns/1ps
module tb_lap_mem_top;

    localparam int AW = 6;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [7:0]    dq_in = '0;
    logic          ce_n = 1'b1, oe_n = 1'b1, strobe = 1'b1;
    logic          prog_en = 1'b0, sig_en = 1'b0;
    logic [7:0]    dq_out;
    logic          dq_oe;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    lap_mem_top #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .dq_in(dq_in),
        .ce_n(ce_n), .oe_n(oe_n), .strobe(strobe), .prog_en(prog_en),
        .sig_en(sig_en), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    // controls ce,oe,strobe,prog,sig | addr | exp_oe | exp_data | req number
    localparam int NV = 14;
    localparam logic [23:0] VT [NV] = '{
        {5'b00100, 6'd5,  1'b1, 8'h24, 4'd4},   // R4 read programmed byte
        {5'b00100, 6'd63, 1'b1, 8'h00, 4'd4},   // R4 top address
        {5'b00100, 6'd0,  1'b1, 8'hFF, 4'd2},   // R2 transparent latch, erased byte
        {5'b10100, 6'd5,  1'b0, 8'h00, 4'd5},   // R5 standby, oe low
        {5'b11100, 6'd5,  1'b0, 8'h00, 4'd5},   // R5 standby, oe high
        {5'b01100, 6'd5,  1'b0, 8'h00, 4'd6},   // R6 output disable
        {5'b00101, 6'd0,  1'b1, 8'h20, 4'd7},   // R7 code for bit0 = 0
        {5'b00101, 6'd1,  1'b1, 8'h80, 4'd7},   // R7 code for bit0 = 1
        {5'b00101, 6'd4,  1'b1, 8'h20, 4'd7},   // R7 even address
        {5'b01101, 6'd1,  1'b0, 8'h00, 4'd7},   // R7 signature with oe high
        {5'b11110, 6'd5,  1'b0, 8'h00, 4'd11},  // R11 inhibit
        {5'b00110, 6'd5,  1'b0, 8'h00, 4'd11},  // R11 both enables low with supply
        {5'b10110, 6'd63, 1'b1, 8'h00, 4'd10},  // R10 verify top address
        {5'b10111, 6'd5,  1'b1, 8'h24, 4'd10}   // R10 verify ignores sig_en
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string tag, logic eoe, logic [7:0] ed);
        n_run++;
        if (dq_oe !== eoe || (eoe && dq_out !== ed)) begin
            n_fail++;
            $display("FAIL %s: oe=%b data=%h expected oe=%b data=%h",
                     tag, dq_oe, dq_out, eoe, ed);
        end
    endtask

    task automatic set_ctl(logic c, logic o, logic s, logic p, logic g);
        ce_n = c; oe_n = o; strobe = s; prog_en = p; sig_en = g;
    endtask

    task automatic read_at(logic [AW-1:0] a);
        set_ctl(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        addr_in = a;
        tick();
    endtask

    task automatic program_at(logic [AW-1:0] a, logic [7:0] d);
        addr_in = a; dq_in = d;
        set_ctl(1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        tick();
        ce_n = 1'b1;
        tick();
    endtask

    task automatic verify_at(logic [AW-1:0] a);
        addr_in = a;
        set_ctl(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        tick();
    endtask

    initial begin
        repeat (4) tick();
        chk("R1 reset state", 1'b0, 8'h00);
        rst_n = 1'b1;
        read_at(6'd3);
        chk("R1 quiet during sweep", 1'b0, 8'h00);
        program_at(6'd3, 8'h00);            // R1 ignored during sweep
        repeat (DEPTH + 4) tick();

        for (int i = 0; i < DEPTH; i++) begin
            read_at(AW'(i));
            chk("R1 erased byte", 1'b1, 8'hFF);
        end

        program_at(6'd5, 8'hA5);
        verify_at(6'd5);
        chk("R8 program then verify", 1'b1, 8'hA5);
        program_at(6'd5, 8'h3C);
        verify_at(6'd5);
        chk("R9 second pulse ANDs", 1'b1, 8'h24);
        program_at(6'd63, 8'h00);
        read_at(6'd62);
        chk("R8 neighbour untouched", 1'b1, 8'hFF);

        for (int v = 0; v < NV; v++) begin
            dq_in = 8'h00;
            set_ctl(VT[v][23], VT[v][22], VT[v][21], VT[v][20], VT[v][19]);
            addr_in = VT[v][18:13];
            tick();
            chk($sformatf("R%0d vector %0d", VT[v][3:0], v), VT[v][12], VT[v][11:4]);
        end

        // R3: held address
        read_at(6'd5);
        strobe = 1'b0; addr_in = 6'd0;
        tick();
        chk("R3 hold ignores new address", 1'b1, 8'h24);
        addr_in = 6'd63;
        tick();
        chk("R3 hold second change", 1'b1, 8'h24);
        strobe = 1'b1;
        tick();
        chk("R2 transparent again", 1'b1, 8'h00);

        // R8 with a latched address
        read_at(6'd10);
        addr_in = 6'd20; dq_in = 8'h0F;
        set_ctl(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        tick();
        ce_n = 1'b1;
        tick();
        read_at(6'd10);
        chk("R8 write used latched address", 1'b1, 8'h0F);
        read_at(6'd20);
        chk("R3 bus address not written", 1'b1, 8'hFF);

        // R11: inhibit writes nothing
        addr_in = 6'd7; dq_in = 8'h00;
        set_ctl(1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        repeat (3) tick();
        read_at(6'd7);
        chk("R11 inhibit no write", 1'b1, 8'hFF);

        // R12: supply removed before rising edge
        addr_in = 6'd8; dq_in = 8'h00;
        set_ctl(1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        tick();
        prog_en = 1'b0;
        tick();
        ce_n = 1'b1;
        tick();
        read_at(6'd8);
        chk("R12 aborted pulse", 1'b1, 8'hFF);

        // R12: pulse without supply
        addr_in = 6'd9; dq_in = 8'h00;
        set_ctl(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        tick();
        ce_n = 1'b1;
        tick();
        read_at(6'd9);
        chk("R12 no supply no write", 1'b1, 8'hFF);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule